// File: doc/BRIEF.md
# UART Transmit Holding Buffer

This block is the transmit half of one serial channel. It has two storage stages. A bus master writes characters into a holding register. A shift stage sends each character out on the serial line, framed by a start bit and a stop bit. An external baud tick sets the bit rate. The block has no other timing source.

The bus side uses a ready flag, `tx_rdy`. While the flag is high and the transmitter is enabled, the holding register takes a character from the bus. An accepted write lowers the flag. When the shift stage goes idle, it takes the held character, and the flag rises again on that same clock edge. Writes made while the flag is low, or while the transmitter is disabled, are lost without trace. They never replace a character that is already waiting.

The `tx_emp` flag reports that both stages are empty, which means the line has gone quiet. Turning the transmitter off lets a character already in flight finish. No new character moves across while the transmitter is off.

Top module: `uart_tx_hold_buf`

## Requirements
- R1: While reset is held and on the first cycle after it, `txd` is 1 and `tx_emp` is 1, and `tx_rdy` equals `tx_en`. The holding register and the shift frame reset to all zeros.
- R2: A write strobe in a cycle where `tx_rdy` is 1 stores `wr_data` in the holding register, and `tx_rdy` reads 0 after that clock edge.
- R3: A write strobe in a cycle where a character is already waiting leaves the waiting character unchanged, and the written value is never transmitted.
- R4: A write strobe while `tx_en` is 0 stores nothing. `tx_rdy` is 0 whenever `tx_en` is 0.
- R5: On any edge where the shift stage is idle, a character is waiting and `tx_en` is 1, the character moves into the shift stage and `tx_rdy` returns to 1 on that same edge.
- R6: A loaded character is sent, starting at the next `baud_tick`, as one 0 start bit, then the data bits LSB first, then one 1 stop bit. Each bit changes on a `baud_tick` cycle and lasts exactly one tick interval. After the stop bit's interval the shift stage is idle.
- R7: `tx_emp` is 1 exactly when no character is waiting and the shift stage is idle.
- R8: When `tx_en` falls, a character already in the shift stage completes its frame. A character waiting in the holding register stays there until `tx_en` is 1 again.
- R9: `txd` is 1 whenever no frame bit is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Bus write strobe for the holding register |
| wr_data | input | DATA_W | Character written by the bus |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emp | output | 1 | Both stages empty |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with the default DATA_W of 8, so each frame is ten bits long. It runs three baud tick spacings: one, four and seven cycles. The one-cycle spacing puts ticks on the load edge and on the edge that ends the stop bit. The wider spacings leave room for write attempts in the middle of a frame, for overwrite attempts on a full holding register, and for turning the transmitter off while one character is on the line and another is waiting.

// File: rtl/txhb_pkg.sv
// Package: shared types for the transmit holding buffer.
// Assumes: nothing beyond the 1800-2017 language.
package txhb_pkg;

    // Phases of the shift stage.
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,   // empty, line high
        SH_ARMED = 2'd1,   // character loaded, waiting for first tick
        SH_SEND  = 2'd2    // frame bits on the line
    } sh_state_e;

    // Number of bits in one frame: start + data + stop.
    function automatic int frame_len(input int data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/txhb_hold_stage.sv
// Module: txhb_hold_stage
// Holding register written from the bus. Captures a character only while
// empty and enabled, and releases it when the shift stage takes it.
// Assumes: take_i is only raised while full_o is 1.
module txhb_hold_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    // A write is accepted only when empty and enabled.
    always_comb begin
        accept = wr_stb && tx_en && !full_q;
    end

    // Holding register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    AST_HELD_NOT_OVERWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_stb) |=> $stable(data_q)); // R3
    AST_OFF_STORES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !full_q) |=> !full_q); // R4
    AST_TAKE_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !full_q); // R5
    AST_TAKE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> full_q); // R5

endmodule

// File: rtl/txhb_shifter.sv
// Module: txhb_shifter
// Shift stage. Frames a loaded character as start, data LSB first, stop,
// advancing one bit per baud tick; the first bit starts at the first tick
// after the load.
// Assumes: load_i is only raised while idle_o is 1.
module txhb_shifter
    import txhb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data,
    output logic              idle_o,
    output logic              txd_o
);

    localparam int FRAME_LEN = frame_len(DATA_W);
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

    sh_state_e            state_q;
    logic [FRAME_LEN-1:0] frame_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 txd_q;

    // Frame register, bit counter and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            frame_q <= '0;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
        end else begin
            case (state_q)
                SH_IDLE: begin
                    if (load_i) begin
                        frame_q <= {1'b1, load_data, 1'b0};
                        state_q <= SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (tick_i) begin
                        txd_q   <= frame_q[0];
                        frame_q <= {1'b0, frame_q[FRAME_LEN-1:1]};
                        cnt_q   <= '0;
                        state_q <= SH_SEND;
                    end
                end
                SH_SEND: begin
                    if (tick_i) begin
                        if (cnt_q == LAST_BIT) begin
                            txd_q   <= 1'b1;
                            state_q <= SH_IDLE;
                        end else begin
                            txd_q   <= frame_q[0];
                            frame_q <= {1'b0, frame_q[FRAME_LEN-1:1]};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign idle_o = (state_q == SH_IDLE);
    assign txd_o  = txd_q;

    AST_LINE_HIGH_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SH_SEND) |-> txd_q); // R9
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_ARMED && tick_i) |=> !txd_q); // R6
    AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SEND && cnt_q == LAST_BIT) |-> txd_q); // R6
    AST_LINE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SEND && !tick_i) |=> $stable(txd_q)); // R6
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (state_q == SH_IDLE)); // R5

endmodule

// File: rtl/uart_tx_hold_buf.sv
// Module: uart_tx_hold_buf
// Two-stage transmit path: bus-written holding register feeding a framing
// shift stage. Generates the ready and empty status flags and the handover.
// Assumes: baud_tick is a single-cycle pulse in the clk domain.
module uart_tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tx_rdy,
    output logic              tx_emp,
    output logic              txd
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              shift_idle;
    logic              handover;

    // Handover from holding register to shift stage.
    always_comb begin
        handover = shift_idle && hold_full && tx_en;
    end

    // Status flags seen by the bus.
    always_comb begin
        tx_rdy = tx_en && !hold_full;
        tx_emp = !hold_full && shift_idle;
    end

    txhb_hold_stage #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take_i  (handover),
        .full_o  (hold_full),
        .data_o  (hold_data)
    );

    txhb_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (baud_tick),
        .load_i    (handover),
        .load_data (hold_data),
        .idle_o    (shift_idle),
        .txd_o     (txd)
    );

    AST_NO_LOAD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && shift_idle) |=> shift_idle); // R8
    AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_emp && tx_en) |-> tx_rdy); // R7
    AST_ACCEPT_LOWERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && wr_stb && !handover) |=> !tx_rdy); // R2

endmodule

// File: tb/test_uart_tx_hold_buf.sv
module test_uart_tx_hold_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       tx_rdy, tx_emp, txd;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string phase = "R1";

    int tick_div = 4;
    int tick_ph = 0;

    // Behavioural reference model.
    bit       m_hv;
    bit [7:0] m_hd;
    bit [7:0] m_ch;
    int       m_st;   // 0 empty, 1 waiting for tick, 2 sending
    int       m_bit;

    always #2 clk = ~clk;

    uart_tx_hold_buf #(.DATA_W(8)) i_uart_tx_hold_buf (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .baud_tick(baud_tick),
        .tx_rdy(tx_rdy), .tx_emp(tx_emp), .txd(txd)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s): %s actual=%0d expected=%0d at %0t",
                     tag, phase, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit load, acc;
        int nst, nbit;
        if (!rst_n) begin
            m_hv = 0; m_hd = 0; m_ch = 0; m_st = 0; m_bit = 0;
            return;
        end
        load = (m_st == 0) && m_hv && tx_en;
        acc  = wr_stb && tx_en && !m_hv;
        nst = m_st; nbit = m_bit;
        if (m_st == 1 && baud_tick) begin nst = 2; nbit = 0; end
        else if (m_st == 2 && baud_tick) begin
            if (m_bit == 9) nst = 0; else nbit = m_bit + 1;
        end
        if (load) begin nst = 1; m_ch = m_hd; m_hv = 0; end
        if (acc) begin m_hv = 1; m_hd = wr_data; end
        m_st = nst; m_bit = nbit;
    endtask

    function automatic bit exp_txd();
        if (m_st != 2) return 1'b1;
        if (m_bit == 0) return 1'b0;
        if (m_bit == 9) return 1'b1;
        return m_ch[m_bit-1];
    endfunction

    task automatic compare_all();
        bit er, ee, et;
        er = tx_en && !m_hv;
        ee = !m_hv && (m_st == 0);
        et = exp_txd();
        chk(txd === et, (m_st == 2) ? "R6" : "R9", "txd", txd, et);
        chk(tx_rdy === er, tx_en ? "R5" : "R4", "tx_rdy", tx_rdy, er);
        chk(tx_emp === ee, "R7", "tx_emp", tx_emp, ee);
    endtask

    // One clock: drive, edge, model, compare away from the edge.
    task automatic cyc(input bit wr, input bit [7:0] d);
        wr_stb  = wr;
        wr_data = d;
        baud_tick = (tick_ph == tick_div - 1);
        tick_ph = baud_tick ? 0 : tick_ph + 1;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(1);
        chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_emp === 1'b1, "R1", "tx_emp after reset", tx_emp, 1);
        chk(tx_rdy === 1'b1, "R1", "tx_rdy after reset", tx_rdy, 1);

        // R2, R5: accept then handover
        phase = "R2";
        cyc(1'b1, 8'hA5);
        chk(tx_rdy === 1'b0, "R2", "tx_rdy after accepted write", tx_rdy, 0);
        cyc(1'b0, 8'h00);
        chk(tx_rdy === 1'b1, "R5", "tx_rdy after handover", tx_rdy, 1);
        cyc(1'b1, 8'h3C);
        // R3: overwrite attempts on a full holding register
        phase = "R3";
        cyc(1'b1, 8'hFF);
        cyc(1'b1, 8'h00);
        run(3);
        cyc(1'b1, 8'hC3);
        run(100);
        chk(tx_emp === 1'b1, "R3", "tx_emp after two frames", tx_emp, 1);

        // R4: writes while disabled
        phase = "R4";
        tx_en = 1'b0;
        cyc(1'b1, 8'h55);
        chk(tx_rdy === 1'b0, "R4", "tx_rdy while disabled", tx_rdy, 0);
        chk(tx_emp === 1'b1, "R4", "tx_emp after dropped write", tx_emp, 1);
        tx_en = 1'b1;
        run(6);
        chk(tx_emp === 1'b1, "R4", "nothing stored by disabled write", tx_emp, 1);

        // R8: disable with one char on the line and one waiting
        phase = "R8";
        cyc(1'b1, 8'h81);
        run(6);
        cyc(1'b1, 8'h7E);
        tx_en = 1'b0;
        run(60);
        chk(txd === 1'b1, "R8", "line idle after frame ends", txd, 1);
        chk(tx_emp === 1'b0, "R8", "waiting char kept while off", tx_emp, 0);
        tx_en = 1'b1;
        run(60);
        chk(tx_emp === 1'b1, "R8", "waiting char sent after enable", tx_emp, 1);

        // R6: tick every cycle
        phase = "R6";
        tick_div = 1; tick_ph = 0;
        cyc(1'b1, 8'h00);
        cyc(1'b1, 8'hFF);
        run(3);
        cyc(1'b1, 8'h01);
        run(40);
        // R6: sparse ticks
        tick_div = 7; tick_ph = 0;
        cyc(1'b1, 8'h96);
        cyc(1'b0, 8'h00);
        cyc(1'b1, 8'h6A);
        run(170);
        chk(tx_emp === 1'b1, "R7", "empty after sparse frames", tx_emp, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule